// File: doc/BRIEF.md
# Radix-4 Complex Butterfly

This block is the arithmetic heart of one radix-4 stage in an inverse FFT datapath. Each transfer presents four complex samples and four complex twiddle factors. Every number is a signed Q1.15 pair: a 16-bit real part and a 16-bit imaginary part. The block scales each sample by its own twiddle. It then merges the four products through two add/subtract layers, one of which rotates a difference by a quarter turn (a multiply by i). The result is four complex outputs.

The arithmetic is purely combinational. A build-time switch places one register stage plus a valid flag behind it, which helps timing closure when many butterflies are chained. Every instance has its own twiddle port, so the twiddle values can differ from one instance to the next. The permutation between stages, the stage sequencing and the source of the twiddles are all left to the surrounding logic.

Top module: `radix4_bfly`

## Requirements
- R1: While `rst_n` is low, and after its release until the first accepted input, `out_valid` is 0 and every `z_re`/`z_im` lane is 0 (registered build).
- R2: For each lane k (k = 0..3), the product m[k] = x[k]·t[k] is formed as re = xr·tr − xi·ti and im = xr·ti + xi·tr at full precision. Each part then gets 2^14 added, is arithmetically shifted right by 15 (round half up) and is clamped to [−32768, 32767].
- R3: The middle layer forms y0 = m0 + m2, y1 = m0 − m2 and y2 = m1 + m3.
- R4: The middle layer forms y3 = i·(m1 − m3). The rotation maps (a, b) to (−b, a), and negating −32768 gives 32767.
- R5: The output layer drives lane 0 = y0 + y2, lane 1 = y1 + y3, lane 2 = y0 − y2 and lane 3 = y1 − y3. Lane k occupies bits [16k+15:16k] of `z_re` and `z_im`, and the same packing applies to the inputs.
- R6: Every addition, subtraction and negation clamps to [−32768, 32767] instead of wrapping.
- R7: With the output register present, `out_valid` equals `in_valid` from one clock earlier, and the outputs show the butterfly of the inputs accepted at that edge.
- R8: With the output register present, a clock edge with `in_valid` low leaves `z_re` and `z_im` unchanged, whatever the data inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Inputs carry a butterfly to compute |
| x_re | input | 64 | Sample real parts, four lanes of 16 bits |
| x_im | input | 64 | Sample imaginary parts, four lanes |
| t_re | input | 64 | Twiddle real parts, four lanes |
| t_im | input | 64 | Twiddle imaginary parts, four lanes |
| out_valid | output | 1 | Outputs hold a fresh result |
| z_re | output | 64 | Result real parts, four lanes |
| z_im | output | 64 | Result imaginary parts, four lanes |

## Verification
Clamping can happen in the product rounding and again in the add/subtract layers within a single evaluation. A product that clamps can then feed a difference that clamps, and that difference is negated by the quarter-turn rotation. The bench provokes this with full-scale negative samples and twiddles on lanes 1 and 3, and with large same-sign products that overflow the output sums. It judges each lane against an independent reference that applies the rounding and clamping rules step by step. Back-to-back valid transfers and idle edges with changing data then confirm that capture and hold never interfere.

// File: rtl/bfly_pkg.sv
package bfly_pkg;
    localparam int DATA_W = 16;
    localparam int ACC_W  = 2 * DATA_W + 2;
    localparam int LANES  = 4;

    typedef struct packed {
        logic signed [DATA_W-1:0] re;
        logic signed [DATA_W-1:0] im;
    } cplx_t;

    // clamp a wide signed value into the DATA_W signed range
    function automatic logic signed [DATA_W-1:0] sat_w(input logic signed [ACC_W-1:0] v);
        logic signed [ACC_W-1:0] hi;
        logic signed [ACC_W-1:0] lo;
        hi = {{(ACC_W-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
        lo = {{(ACC_W-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};
        if (v > hi)
            return {1'b0, {(DATA_W-1){1'b1}}};
        else if (v < lo)
            return {1'b1, {(DATA_W-1){1'b0}}};
        else
            return v[DATA_W-1:0];
    endfunction
endpackage

// File: rtl/bfly_cmul.sv
module bfly_cmul
    import bfly_pkg::*;
#(
    parameter int FRAC_W = DATA_W - 1
) (
    input  cplx_t a,
    input  cplx_t b,
    output cplx_t p
);
    localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1) << (FRAC_W - 1);

    logic signed [ACC_W-1:0] rr, ii, ri, ir;
    logic signed [ACC_W-1:0] re_acc, im_acc;

    always_comb begin
        rr     = a.re * b.re;
        ii     = a.im * b.im;
        ri     = a.re * b.im;
        ir     = a.im * b.re;
        re_acc = ((rr - ii) + HALF) >>> FRAC_W;
        im_acc = ((ri + ir) + HALF) >>> FRAC_W;
    end

    assign p.re = sat_w(re_acc);
    assign p.im = sat_w(im_acc);

    // R2: a zero factor gives a zero product after rounding
    always_comb begin
        if (b == '0) begin
            a_r2_zero_factor: assert (p == '0);
        end
    end
endmodule

// File: rtl/bfly_addsub.sv
module bfly_addsub
    import bfly_pkg::*;
#(
    parameter bit SUB = 1'b0
) (
    input  cplx_t a,
    input  cplx_t b,
    output cplx_t s
);
    logic signed [ACC_W-1:0] re_w, im_w;

    generate
        if (SUB) begin : g_sub
            always_comb begin
                re_w = a.re - b.re;
                im_w = a.im - b.im;
            end
            // R6: non-negative minus negative never wraps below zero
            always_comb begin
                if (a.re >= 0 && b.re < 0) begin
                    a_r6_sub_no_wrap: assert (s.re >= 0);
                end
            end
        end else begin : g_add
            always_comb begin
                re_w = a.re + b.re;
                im_w = a.im + b.im;
            end
            // R6: same-sign operands keep their sign
            always_comb begin
                if (a.re >= 0 && b.re >= 0) begin
                    a_r6_add_pos_no_wrap: assert (s.re >= 0);
                end
                if (a.re < 0 && b.re < 0) begin
                    a_r6_add_neg_no_wrap: assert (s.re < 0);
                end
            end
        end
    endgenerate

    assign s.re = sat_w(re_w);
    assign s.im = sat_w(im_w);
endmodule

// File: rtl/radix4_bfly.sv
module radix4_bfly
    import bfly_pkg::*;
#(
    parameter int FRAC_W  = DATA_W - 1,
    parameter bit REG_OUT = 1'b1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    input  logic [LANES-1:0][DATA_W-1:0]  x_re,
    input  logic [LANES-1:0][DATA_W-1:0]  x_im,
    input  logic [LANES-1:0][DATA_W-1:0]  t_re,
    input  logic [LANES-1:0][DATA_W-1:0]  t_im,
    output logic                          out_valid,
    output logic [LANES-1:0][DATA_W-1:0]  z_re,
    output logic [LANES-1:0][DATA_W-1:0]  z_im
);
    localparam int HALF_L = LANES / 2;

    cplx_t x_c [LANES];
    cplx_t t_c [LANES];
    cplx_t m_c [LANES];
    cplx_t y_c [LANES];
    cplx_t z_c [LANES];
    cplx_t s1  [HALF_L];
    cplx_t d1  [HALF_L];
    cplx_t s2  [HALF_L];
    cplx_t d2  [HALF_L];
    cplx_t rot;

    logic signed [ACC_W-1:0] neg_im;

    // twiddle products, one multiplier per lane
    generate
        for (genvar k = 0; k < LANES; k++) begin : g_lane
            assign x_c[k].re = x_re[k];
            assign x_c[k].im = x_im[k];
            assign t_c[k].re = t_re[k];
            assign t_c[k].im = t_im[k];
            bfly_cmul #(.FRAC_W(FRAC_W)) u_mul (
                .a (x_c[k]),
                .b (t_c[k]),
                .p (m_c[k])
            );
        end
    endgenerate

    // first add/subtract layer: pairs k and k+2
    generate
        for (genvar j = 0; j < HALF_L; j++) begin : g_l1
            bfly_addsub #(.SUB(1'b0)) u_sum (.a(m_c[j]), .b(m_c[j+HALF_L]), .s(s1[j]));
            bfly_addsub #(.SUB(1'b1)) u_dif (.a(m_c[j]), .b(m_c[j+HALF_L]), .s(d1[j]));
        end
    endgenerate

    // quarter-turn on the odd difference: (a, b) -> (-b, a)
    always_comb begin
        neg_im = d1[1].im;
        neg_im = -neg_im;
        rot.re = sat_w(neg_im);
        rot.im = d1[1].re;
    end

    always_comb begin
        y_c[0] = s1[0];
        y_c[1] = d1[0];
        y_c[2] = s1[1];
        y_c[3] = rot;
    end

    // second add/subtract layer
    generate
        for (genvar j = 0; j < HALF_L; j++) begin : g_l2
            bfly_addsub #(.SUB(1'b0)) u_sum (.a(y_c[j]), .b(y_c[j+HALF_L]), .s(s2[j]));
            bfly_addsub #(.SUB(1'b1)) u_dif (.a(y_c[j]), .b(y_c[j+HALF_L]), .s(d2[j]));
            assign z_c[j]        = s2[j];
            assign z_c[j+HALF_L] = d2[j];
        end
    endgenerate

    // R5: all-zero samples must give an all-zero result
    always_comb begin
        if (x_re == '0 && x_im == '0) begin
            for (int k = 0; k < LANES; k++) begin
                a_r5_zero_in_zero_out: assert (z_c[k] == '0);
            end
        end
    end

    generate
        if (REG_OUT) begin : g_reg
            typedef struct packed {
                logic                         valid;
                logic [LANES-1:0][DATA_W-1:0] re;
                logic [LANES-1:0][DATA_W-1:0] im;
            } stage_t;

            stage_t st_d, st_q;

            always_comb begin
                st_d       = st_q;
                st_d.valid = in_valid;
                if (in_valid) begin
                    for (int k = 0; k < LANES; k++) begin
                        st_d.re[k] = z_c[k].re;
                        st_d.im[k] = z_c[k].im;
                    end
                end
            end

            always_ff @(posedge clk) begin
                if (!rst_n)
                    st_q <= '0;
                else
                    st_q <= st_d;
            end

            assign out_valid = st_q.valid;
            assign z_re      = st_q.re;
            assign z_im      = st_q.im;

            a_r7_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |=> out_valid);
            a_r7_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
                !in_valid |=> !out_valid);
            a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
                !in_valid |=> ($stable(z_re) && $stable(z_im)));
        end else begin : g_comb
            always_comb begin
                out_valid = in_valid;
                for (int k = 0; k < LANES; k++) begin
                    z_re[k] = z_c[k].re;
                    z_im[k] = z_c[k].im;
                end
            end
        end
    endgenerate
endmodule

// File: tb/radix4_bfly_bench.sv
module radix4_bfly_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [3:0][15:0]  x_re = '0, x_im = '0, t_re = '0, t_im = '0;
    logic              out_valid;
    logic [3:0][15:0]  z_re, z_im;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;
    int exp_re [4];
    int exp_im [4];
    logic [31:0] seed = 32'h1234_5678;

    always #(CLK_PERIOD/2) clk = ~clk;

    radix4_bfly u_radix4_bfly (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .x_re(x_re), .x_im(x_im), .t_re(t_re), .t_im(t_im),
        .out_valid(out_valid), .z_re(z_re), .z_im(z_im)
    );

    function automatic int clamp(longint v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return int'(v);
    endfunction

    // reference model built from R2..R6
    task automatic model();
        int mr[4], mi[4], yr[4], yi[4], dr, di;
        for (int k = 0; k < 4; k++) begin
            longint a = $signed(x_re[k]), b = $signed(x_im[k]);
            longint c = $signed(t_re[k]), d = $signed(t_im[k]);
            mr[k] = clamp((a*c - b*d + 16384) >>> 15);
            mi[k] = clamp((a*d + b*c + 16384) >>> 15);
        end
        yr[0] = clamp(mr[0] + mr[2]); yi[0] = clamp(mi[0] + mi[2]);
        yr[1] = clamp(mr[0] - mr[2]); yi[1] = clamp(mi[0] - mi[2]);
        yr[2] = clamp(mr[1] + mr[3]); yi[2] = clamp(mi[1] + mi[3]);
        dr = clamp(mr[1] - mr[3]);    di = clamp(mi[1] - mi[3]);
        yr[3] = clamp(-di);           yi[3] = dr;
        exp_re[0] = clamp(yr[0] + yr[2]); exp_im[0] = clamp(yi[0] + yi[2]);
        exp_re[1] = clamp(yr[1] + yr[3]); exp_im[1] = clamp(yi[1] + yi[3]);
        exp_re[2] = clamp(yr[0] - yr[2]); exp_im[2] = clamp(yi[0] - yi[2]);
        exp_re[3] = clamp(yr[1] - yr[3]); exp_im[3] = clamp(yi[1] - yi[3]);
    endtask

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic check_lanes(string tag);
        for (int k = 0; k < 4; k++) begin
            chk($sformatf("%s lane%0d re", tag, k), $signed(z_re[k]), exp_re[k]);
            chk($sformatf("%s lane%0d im", tag, k), $signed(z_im[k]), exp_im[k]);
        end
    endtask

    task automatic set_lane(int k, int xr, int xi, int tr, int ti);
        x_re[k] = 16'(xr); x_im[k] = 16'(xi);
        t_re[k] = 16'(tr); t_im[k] = 16'(ti);
    endtask

    // drive one valid transfer at a falling edge, check after the next one
    task automatic fire(string tag);
        in_valid = 1'b1;
        model();
        @(negedge clk);
        chk({tag, " R7 out_valid"}, int'(out_valid), 1);
        check_lanes(tag);
        in_valid = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 valid in reset", int'(out_valid), 0);
        chk("R1 z_re in reset", int'(z_re != '0), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 valid after release", int'(out_valid), 0);
        chk("R1 z_im after release", int'(z_im != '0), 0);
    endtask

    task automatic t_unit_twiddle();
        set_lane(0, 1000, -200, 32767, 0);
        set_lane(1, -3000, 400, 32767, 0);
        set_lane(2, 250, 5000, 32767, 0);
        set_lane(3, 7, -7, 32767, 0);
        fire("R2 R3 R5 near-unit twiddle");
    endtask

    task automatic t_rotate_only();
        // only lane 1 nonzero: lane1 = i*m1, lane3 = -i*m1 (R4)
        set_lane(0, 0, 0, 0, 0);
        set_lane(1, 12000, -9000, 16384, 16384);
        set_lane(2, 0, 0, 0, 0);
        set_lane(3, 0, 0, 0, 0);
        fire("R4 quarter turn");
    endtask

    task automatic t_product_clamp();
        set_lane(0, -32768, -32768, -32768, -32768);
        set_lane(1, -32768, 0, -32768, 0);
        set_lane(2, 1, 1, 1, 1);
        set_lane(3, 3, -1, 16384, 0);
        fire("R2 product clamp");
    endtask

    task automatic t_rotate_clamp();
        // m1.im = -32767, m3.im = 32767 -> difference clamps, negation clamps
        set_lane(0, 0, 0, 0, 0);
        set_lane(1, 0, 32767, -32768, 0);
        set_lane(2, 0, 0, 0, 0);
        set_lane(3, 0, -32768, -32768, 0);
        fire("R4 R6 rotate clamp");
    endtask

    task automatic t_sum_clamp();
        for (int k = 0; k < 4; k++) set_lane(k, 30000, -30000, 32767, 0);
        fire("R6 sum clamp");
    endtask

    task automatic t_patterns();
        for (int n = 0; n < 20; n++) begin
            for (int k = 0; k < 4; k++) begin
                int v[4];
                for (int q = 0; q < 4; q++) begin
                    seed = seed * 32'd1664525 + 32'd1013904223;
                    v[q] = int'($signed(seed[31:16]));
                end
                set_lane(k, v[0], v[1], v[2], v[3]);
            end
            fire($sformatf("R2 R3 R4 R5 R6 pattern %0d", n));
        end
    endtask

    task automatic t_hold();
        int held_re[4], held_im[4];
        set_lane(0, 500, 600, 20000, -100);
        set_lane(1, -50, 70, 3000, 3000);
        set_lane(2, 9, 9, 9, 9);
        set_lane(3, 1111, -2222, -16384, 8000);
        fire("R7 before hold");
        for (int k = 0; k < 4; k++) begin
            held_re[k] = exp_re[k];
            held_im[k] = exp_im[k];
        end
        for (int n = 0; n < 3; n++) begin
            for (int k = 0; k < 4; k++) set_lane(k, -20000 + n, 12345, 32767, -32768);
            @(negedge clk);
            chk("R7 idle valid low", int'(out_valid), 0);
            for (int k = 0; k < 4; k++) begin
                chk("R8 hold re", $signed(z_re[k]), held_re[k]);
                chk("R8 hold im", $signed(z_im[k]), held_im[k]);
            end
        end
    endtask

    task automatic t_back_to_back();
        for (int n = 0; n < 4; n++) begin
            for (int k = 0; k < 4; k++) set_lane(k, 1000 * (n + 1) - k, -700 * k, 20000 - 3000 * n, 5000 * k);
            in_valid = 1'b1;
            model();
            @(negedge clk);
            chk("R7 streaming valid", int'(out_valid), 1);
            check_lanes("R7 streaming");
        end
        in_valid = 1'b0;
        @(negedge clk);
        chk("R7 valid drops", int'(out_valid), 0);
    endtask

    initial begin
        t_reset();
        t_unit_twiddle();
        t_rotate_only();
        t_product_clamp();
        t_rotate_clamp();
        t_sum_clamp();
        t_patterns();
        t_hold();
        t_back_to_back();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R7 watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule